// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block applies the architectural state changes of exception entry on a 32-bit RISC core. The core offers one request per cycle, carrying a cause code, its current machine state word, the address of the current instruction and the address of the next one. One cycle later the block presents four registered results together with a one-cycle completion pulse:

- the first save register (the return address);
- the second save register (the saved machine state);
- the updated machine state word;
- the redirected fetch address.

A maskable cause that arrives while interrupts are disabled leaves all four results unchanged. An unknown cause also leaves them unchanged, and it raises a fatal flag that stays set until reset. The core copies the results into its architectural registers when the pulse arrives, and between entries the outputs keep the last state produced.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `pc_o` is 0xFFF00100, `msr_o` is 0x00000040, `srr0_o` and `srr1_o` are 0, and `fatal_o` and `done_o` are 0.
- R2: On a taken entry, `srr0_o` takes `next_pc_i`. The exception is the program/trap cause (code 3), where it takes `cur_pc_i`.
- R3: On a taken entry, `srr1_o` equals `msr_i & 0x0000FF73`. For the program/trap cause, bit 17 (0x00020000) is also set.
- R4: On a taken entry, the new machine state is `msr_i` with these bits cleared: 18 power-save, 15 interrupt enable, 14 user mode, 13 float available, 11 and 8 float exception modes, 10 single step, 9 branch trace, 5 instruction translation, 4 data translation and 1 recoverable. All other bits are kept, apart from bit 0 (see R5).
- R5: On a taken entry, bit 0 (little-endian) of the new machine state is set equal to bit 16 (interrupt little-endian) of `msr_i`.
- R6: On a taken entry, `pc_o` is the vector base OR the cause offset. The base is 0xFFF00000 when bit 6 (vector prefix) of `msr_i` is 1, and 0x00000000 when it is 0.
- R7: The cause codes and their offsets are:
  - 0 external interrupt: 0x0500
  - 1 decrementer: 0x0900
  - 2 system-management interrupt: 0x1400
  - 3 program/trap: 0x0700
  - 4 system call: 0x0C00
  - 5 data storage: 0x0300
  - 6 instruction storage: 0x0400
- R8: Causes 0, 1 and 2 arriving with bit 15 of `msr_i` clear change none of the four state outputs.
- R9: Causes 3 to 6 are taken whatever the value of bit 15 of `msr_i`.
- R10: Cause code 7 sets `fatal_o` and changes none of the four state outputs. `fatal_o` then stays 1 until reset, and later requests are still processed.
- R11: `done_o` is 1 for exactly the one cycle after each cycle in which `req_valid_i` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Entry request strobe |
| cause_i | input | 3 | Exception cause code |
| msr_i | input | 32 | Current machine state word |
| cur_pc_i | input | 32 | Address of the current instruction |
| next_pc_i | input | 32 | Address of the next instruction |
| srr0_o | output | 32 | First save register value |
| srr1_o | output | 32 | Second save register value |
| msr_o | output | 32 | Updated machine state word |
| pc_o | output | 32 | Redirected fetch address |
| done_o | output | 1 | One-cycle completion pulse |
| fatal_o | output | 1 | Sticky unknown-cause flag |

## Verification
Each of the seven causes is driven twice, once with the machine state all ones and once all zeros. This separates the cleared bits from the kept bits in the new machine state, the saved-state mask, and the two vector bases. Sparse machine-state words follow, including one with only the interrupt little-endian bit set and one with only the interrupt-enable bit set. These show whether the little-endian copy follows the input and whether the enable bit gates only the three maskable causes. Unknown codes are placed between valid entries, which shows that the outputs hold, that the fatal flag stays set, and that later entries still proceed.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int unsigned XLEN = 32;

    typedef enum logic [2:0] {
        CAUSE_EXT   = 3'd0,
        CAUSE_DEC   = 3'd1,
        CAUSE_SMI   = 3'd2,
        CAUSE_TRAP  = 3'd3,
        CAUSE_SYSC  = 3'd4,
        CAUSE_DSTOR = 3'd5,
        CAUSE_ISTOR = 3'd6,
        CAUSE_BAD   = 3'd7
    } cause_e;

    localparam int unsigned BIT_LE  = 0;
    localparam int unsigned BIT_IP  = 6;
    localparam int unsigned BIT_EE  = 15;
    localparam int unsigned BIT_ILE = 16;

    localparam logic [XLEN-1:0] SAVE_MASK  = 32'h0000_FF73;
    localparam logic [XLEN-1:0] TRAP_FLAG  = 32'h0002_0000;
    localparam logic [XLEN-1:0] CLEAR_MASK = 32'h0004_EF32;
    localparam logic [XLEN-1:0] HIGH_BASE  = 32'hFFF0_0000;

    typedef struct packed {
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] pc;
        logic            fatal;
        logic            done;
    } entry_state_t;

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
(
    input  logic [2:0]  cause_i,
    input  logic        ee_i,
    output logic [15:0] offset_o,
    output logic        known_o,
    output logic        take_o,
    output logic        trap_o
);
    logic maskable;

    always_comb begin
        offset_o = 16'h0000;
        known_o  = 1'b1;
        maskable = 1'b0;
        unique case (cause_e'(cause_i))
            CAUSE_EXT:   begin offset_o = 16'h0500; maskable = 1'b1; end
            CAUSE_DEC:   begin offset_o = 16'h0900; maskable = 1'b1; end
            CAUSE_SMI:   begin offset_o = 16'h1400; maskable = 1'b1; end
            CAUSE_TRAP:  offset_o = 16'h0700;
            CAUSE_SYSC:  offset_o = 16'h0C00;
            CAUSE_DSTOR: offset_o = 16'h0300;
            CAUSE_ISTOR: offset_o = 16'h0400;
            default:     known_o  = 1'b0;
        endcase
        take_o = known_o && (!maskable || ee_i);
        trap_o = (cause_e'(cause_i) == CAUSE_TRAP);
    end

endmodule

// File: rtl/exc_msr_xform.sv
module exc_msr_xform
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] msr_i,
    input  logic            trap_i,
    output logic [XLEN-1:0] msr_new_o,
    output logic [XLEN-1:0] save_o
);
    always_comb begin
        save_o = msr_i & SAVE_MASK;
        if (trap_i) begin
            save_o = save_o | TRAP_FLAG;
        end
        msr_new_o         = msr_i & ~CLEAR_MASK;
        msr_new_o[BIT_LE] = msr_i[BIT_ILE];
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] RESET_PC  = 32'hFFF0_0100,
    parameter logic [31:0] RESET_MSR = 32'h0000_0040
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid_i,
    input  logic [2:0]  cause_i,
    input  logic [31:0] msr_i,
    input  logic [31:0] cur_pc_i,
    input  logic [31:0] next_pc_i,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o,
    output logic [31:0] pc_o,
    output logic        done_o,
    output logic        fatal_o
);
    entry_state_t    st_d, st_q;
    logic [15:0]     vec_off;
    logic            known, take, trap;
    logic [XLEN-1:0] msr_new, save_word, vec_base;

    exc_vector_sel u_vsel (
        .cause_i  (cause_i),
        .ee_i     (msr_i[BIT_EE]),
        .offset_o (vec_off),
        .known_o  (known),
        .take_o   (take),
        .trap_o   (trap)
    );

    exc_msr_xform u_xform (
        .msr_i     (msr_i),
        .trap_i    (trap),
        .msr_new_o (msr_new),
        .save_o    (save_word)
    );

    always_comb begin
        vec_base = msr_i[BIT_IP] ? HIGH_BASE : '0;
        st_d      = st_q;
        st_d.done = req_valid_i;
        if (req_valid_i) begin
            if (!known) begin
                st_d.fatal = 1'b1;
            end else if (take) begin
                st_d.srr0 = trap ? cur_pc_i : next_pc_i;
                st_d.srr1 = save_word;
                st_d.msr  = msr_new;
                st_d.pc   = vec_base | {16'h0000, vec_off};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.srr0  <= '0;
            st_q.srr1  <= '0;
            st_q.msr   <= RESET_MSR;
            st_q.pc    <= RESET_PC;
            st_q.fatal <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign srr0_o  = st_q.srr0;
    assign srr1_o  = st_q.srr1;
    assign msr_o   = st_q.msr;
    assign pc_o    = st_q.pc;
    assign done_o  = st_q.done;
    assign fatal_o = st_q.fatal;

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o); // R10
    AST_BAD_CAUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cause_i == 3'd7) |=> (fatal_o && $stable(pc_o) && $stable(msr_o))); // R10
    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> done_o); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !done_o); // R11
    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cause_i <= 3'd2 && !msr_i[15]) |=> ($stable(pc_o) && $stable(srr0_o) && $stable(srr1_o))); // R8
    AST_LE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msr_o) |-> (msr_o[0] == msr_o[16])); // R5
    AST_VECTOR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o[7:0] == 8'h00) && (pc_o[19:16] == 4'h0)); // R6
    AST_EE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cause_i >= 3'd3 && cause_i <= 3'd6) |=> !msr_o[15]); // R9

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

    typedef struct {
        logic [31:0] srr0, srr1, msr, pc;
        logic        fatal;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  cause_i = '0;
    logic [31:0] msr_i = '0, cur_pc_i = '0, next_pc_i = '0;
    logic [31:0] srr0_o, srr1_o, msr_o, pc_o;
    logic        done_o, fatal_o;

    int tests = 0;
    int fails = 0;
    exp_t q[$];

    logic [31:0] m_srr0 = 32'h0, m_srr1 = 32'h0, m_msr = 32'h40, m_pc = 32'hFFF00100;
    logic        m_fatal = 1'b0;

    always #4 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .cause_i(cause_i),
        .msr_i(msr_i), .cur_pc_i(cur_pc_i), .next_pc_i(next_pc_i),
        .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o), .pc_o(pc_o),
        .done_o(done_o), .fatal_o(fatal_o)
    );

    function automatic logic [15:0] off_of(input logic [2:0] c);
        case (c)
            3'd0: return 16'h0500;
            3'd1: return 16'h0900;
            3'd2: return 16'h1400;
            3'd3: return 16'h0700;
            3'd4: return 16'h0C00;
            3'd5: return 16'h0300;
            default: return 16'h0400;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] c, input logic [31:0] m, input logic [31:0] cur,
                        input logic [31:0] nxt, input string tag);
        exp_t e;
        if (c == 3'd7) begin
            m_fatal = 1'b1;
        end else if (c >= 3'd3 || m[15]) begin
            m_srr0 = (c == 3'd3) ? cur : nxt;
            m_srr1 = (m & 32'h0000FF73) | ((c == 3'd3) ? 32'h00020000 : 32'h0);
            m_msr  = m & ~32'h0004EF32;
            m_msr[0] = m[16];
            m_pc   = (m[6] ? 32'hFFF00000 : 32'h0) | {16'h0, off_of(c)};
        end
        e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_msr; e.pc = m_pc;
        e.fatal = m_fatal; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid_i = 1'b1; cause_i = c; msr_i = m; cur_pc_i = cur; next_pc_i = nxt;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Monitor: pops one expected item per completion pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (q.size() == 0) begin
                    check("R11", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, "srr0", srr0_o, e.srr0);
                    check(e.tag, "srr1", srr1_o, e.srr1);
                    check(e.tag, "msr", msr_o, e.msr);
                    check(e.tag, "pc", pc_o, e.pc);
                    check(e.tag, "fatal", {31'h0, fatal_o}, {31'h0, e.fatal});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "pc", pc_o, 32'hFFF00100);
        check("R1", "msr", msr_o, 32'h00000040);
        check("R1", "srr0", srr0_o, 32'h0);
        check("R1", "srr1", srr1_o, 32'h0);
        check("R1", "done", {31'h0, done_o}, 32'h0);
        check("R1", "fatal", {31'h0, fatal_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 R4 R3 R6: all causes with all-ones and all-zero state words
        for (int c = 0; c < 7; c++) begin
            send(3'(c), 32'hFFFFFFFF, 32'h00001000 + 32'(c * 8), 32'h00001004 + 32'(c * 8), "R7");
            send(3'(c), 32'h00000000, 32'h00002000, 32'h00002004, "R9");
        end
        // R2 trap saves current address, system call saves next
        send(3'd3, 32'h00008040, 32'hA0000010, 32'hA0000014, "R2");
        send(3'd4, 32'h00008040, 32'hA0000020, 32'hA0000024, "R2");
        // R5 little-endian copy, both ways
        send(3'd5, 32'h00010000, 32'h3000, 32'h3004, "R5");
        send(3'd6, 32'h00000001, 32'h3100, 32'h3104, "R5");
        // R8 masked causes hold state
        send(3'd0, 32'h00000040, 32'h4000, 32'h4004, "R8");
        send(3'd1, 32'h00017FFF, 32'h4100, 32'h4104, "R8");
        send(3'd2, 32'h00000000, 32'h4200, 32'h4204, "R8");
        send(3'd0, 32'h00008000, 32'h4300, 32'h4304, "R6");
        // R10 unknown cause, sticky flag, later entries still processed
        send(3'd7, 32'hFFFFFFFF, 32'h5000, 32'h5004, "R10");
        send(3'd1, 32'h0000C040, 32'h5100, 32'h5104, "R10");
        // R11 back-to-back: done held two cycles then low
        begin
            exp_t e;
            m_srr0 = 32'h6004; m_srr1 = 32'h0000C040 & 32'h0000FF73;
            m_msr = 32'h00000040; m_pc = 32'hFFF01400;
            e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_msr; e.pc = m_pc; e.fatal = 1'b1; e.tag = "R11";
            q.push_back(e);
            m_srr0 = 32'h6108; m_srr1 = 32'h00000040;
            m_msr = 32'h00000040; m_pc = 32'hFFF00C00;
            e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_msr; e.pc = m_pc;
            q.push_back(e);
            @(negedge clk);
            req_valid_i = 1'b1; cause_i = 3'd2; msr_i = 32'h0000C040; next_pc_i = 32'h6004;
            @(negedge clk);
            cause_i = 3'd4; msr_i = 32'h00000040; next_pc_i = 32'h6108;
            @(negedge clk);
            req_valid_i = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check("R11", "done idle", {31'h0, done_o}, 32'h0);
        end
        check("R11", "queue drained", 32'(q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R11 watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule